// File: doc/BRIEF.md
# Cascaded Quantizer Result Combiner

This block is the final competition stage that lets several nearest-neighbour encoder units act as one larger vector quantizer. The encoder units and the codebook storage are outside it. It accepts, in the same cycle, the results of every unit and returns one winning index together with its distance.

Two ways of joining units are supported, chosen per transaction by a mode input. When the codebook is split across units, each unit reports only its own winner (a distance and a local index); the combiner picks the unit whose winner is closest and forms a global index by putting the unit number above the local index. When the vector components are split across units, each unit reports a partial distance for every codevector of a shared codebook; the combiner adds the partial distances of each codevector over all units and then searches the totals for the smallest one.

With the default parameters, two units of 32 codevectors each form a 64-entry codebook, distances are 12 bits wide and the reported distance is 13 bits wide. The result is registered and announced by a one-cycle valid strobe.

Top module: `vq_cascade_combiner`

## Requirements
- R1: While reset is held and in the cycle after its release, out_valid, out_idx and out_dist are all zero.
- R2: out_valid is high for exactly one cycle, in the cycle after each cycle in which in_valid is high, and is low otherwise.
- R3: With mode_dim = 0 (split codebook), out_dist equals the smallest of the units' winning distances, zero-extended to the output width.
- R4: With mode_dim = 0, out_idx is the winning unit number in the upper bits followed by that unit's local index in the lower bits; with defaults, bit 5 holds the unit number and bits 4:0 the local index.
- R5: With mode_dim = 0, equal winning distances resolve to the lower-numbered unit.
- R6: With mode_dim = 1 (split vector), out_dist is the smallest over codevectors of the sum of that codevector's partial distances across all units, and out_idx is that codevector's index with the upper unit-number bits zero.
- R7: With mode_dim = 1, equal totals resolve to the lower codevector index.
- R8: The reported distance is wide enough that the sum of all units' maximum partial distances is reported exactly (with defaults 2 x 4095 = 8190).
- R9: mode_dim and all data inputs are sampled only in a cycle with in_valid high; while in_valid is low out_idx and out_dist keep their last values.
- R10: In mode 0 the partial-distance inputs have no effect on the result; in mode 1 the winning-distance and local-index inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle strobe marking valid unit results |
| mode_dim | input | 1 | 0 = split codebook, 1 = split vector components |
| win_dist_flat | input | N_UNITS*DIST_W | Winning distance of each unit, unit u at bits u*DIST_W upward |
| win_idx_flat | input | N_UNITS*LOC_W | Local winning index of each unit, unit u at bits u*LOC_W upward |
| part_dist_flat | input | N_UNITS*N_CODE*DIST_W | Partial distance of codevector k from unit u at bits (u*N_CODE+k)*DIST_W upward |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_idx | output | UNIT_W+LOC_W | Final codebook index |
| out_dist | output | DIST_W+UNIT_W | Final winning distance |

## Verification
The bench aims at ties in both modes: a design comparing with less-or-equal would report unit 1 or the later codevector instead of the first. It drives every partial distance at its maximum, where a sum kept at the input width would wrap and report a small value, and it swaps the unit order of the winner to catch a global index built with the fields reversed. It also changes inputs and mode between strobes and scrambles the inputs of the unused mode, which a design that samples without the strobe or mixes the two data paths would let leak into the result.

// File: rtl/vqc_pkg.sv
package vqc_pkg;
  typedef enum logic {
    MODE_BOOK = 1'b0,
    MODE_DIM  = 1'b1
  } comb_mode_e;
endpackage

// File: rtl/vqc_sum_lane.sv
module vqc_sum_lane #(
  parameter int N_UNITS = 2,
  parameter int DIST_W  = 12,
  parameter int SUM_W   = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_UNITS*DIST_W-1:0]   parts_flat,
  output logic [SUM_W-1:0]            total
);
  always_comb begin
    total = '0;
    for (int u = 0; u < N_UNITS; u++)
      total = total + SUM_W'(parts_flat[u*DIST_W +: DIST_W]);
  end

  // event wire: some addend exceeds the total, i.e. the sum wrapped
  logic wrap_seen;
  always_comb begin
    wrap_seen = 1'b0;
    for (int u = 0; u < N_UNITS; u++)
      if (SUM_W'(parts_flat[u*DIST_W +: DIST_W]) > total) wrap_seen = 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !wrap_seen); // R8
endmodule

// File: rtl/vqc_argmin.sv
module vqc_argmin #(
  parameter int CNT = 2,
  parameter int W   = 13,
  parameter int IW  = (CNT > 1) ? $clog2(CNT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT*W-1:0]   cand_flat,
  output logic [IW-1:0]      best_idx,
  output logic [W-1:0]       best_val
);
  // strict less-than: the first of equal candidates is kept
  always_comb begin
    best_idx = '0;
    best_val = cand_flat[0 +: W];
    for (int i = 1; i < CNT; i++) begin
      if (cand_flat[i*W +: W] < best_val) begin
        best_idx = IW'(i);
        best_val = cand_flat[i*W +: W];
      end
    end
  end

  // event wires for the checks below
  logic below_best;
  logic earlier_equal;
  always_comb begin
    below_best    = 1'b0;
    earlier_equal = 1'b0;
    for (int i = 0; i < CNT; i++) begin
      if (cand_flat[i*W +: W] < best_val) below_best = 1'b1;
      if ((IW'(i) < best_idx) && (cand_flat[i*W +: W] == best_val)) earlier_equal = 1'b1;
    end
  end

  AST_MIN_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n) !below_best); // R3
  AST_TIE_TO_FIRST:  assert property (@(posedge clk) disable iff (!rst_n) !earlier_equal); // R7
endmodule

// File: rtl/vq_cascade_combiner.sv
module vq_cascade_combiner #(
  parameter int N_UNITS = 2,
  parameter int N_CODE  = 32,
  parameter int DIST_W  = 12,
  parameter int UNIT_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
  parameter int LOC_W   = (N_CODE > 1) ? $clog2(N_CODE) : 1,
  parameter int GIDX_W  = UNIT_W + LOC_W,
  parameter int SUM_W   = DIST_W + UNIT_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic                              mode_dim,
  input  logic [N_UNITS*DIST_W-1:0]         win_dist_flat,
  input  logic [N_UNITS*LOC_W-1:0]          win_idx_flat,
  input  logic [N_UNITS*N_CODE*DIST_W-1:0]  part_dist_flat,
  output logic                              out_valid,
  output logic [GIDX_W-1:0]                 out_idx,
  output logic [SUM_W-1:0]                  out_dist
);
  import vqc_pkg::*;

  comb_mode_e mode_sel;
  assign mode_sel = comb_mode_e'(mode_dim);

  // ---- split codebook path: compare the units' winners ----
  logic [N_UNITS*SUM_W-1:0] book_cand;
  for (genvar u = 0; u < N_UNITS; u++) begin : g_book
    assign book_cand[u*SUM_W +: SUM_W] = SUM_W'(win_dist_flat[u*DIST_W +: DIST_W]);
  end

  logic [UNIT_W-1:0] book_unit;
  logic [SUM_W-1:0]  book_dist;
  vqc_argmin #(.CNT(N_UNITS), .W(SUM_W), .IW(UNIT_W)) u_book_min (
    .clk(clk), .rst_n(rst_n), .cand_flat(book_cand),
    .best_idx(book_unit), .best_val(book_dist)
  );

  logic [LOC_W-1:0] book_local;
  assign book_local = win_idx_flat[book_unit*LOC_W +: LOC_W];

  // ---- split vector path: add partials per codevector, then search ----
  logic [N_CODE*SUM_W-1:0] dim_cand;
  for (genvar k = 0; k < N_CODE; k++) begin : g_lane
    logic [N_UNITS*DIST_W-1:0] lane_parts;
    for (genvar u = 0; u < N_UNITS; u++) begin : g_gather
      assign lane_parts[u*DIST_W +: DIST_W] = part_dist_flat[(u*N_CODE+k)*DIST_W +: DIST_W];
    end
    vqc_sum_lane #(.N_UNITS(N_UNITS), .DIST_W(DIST_W), .SUM_W(SUM_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .parts_flat(lane_parts),
      .total(dim_cand[k*SUM_W +: SUM_W])
    );
  end

  logic [LOC_W-1:0] dim_code;
  logic [SUM_W-1:0] dim_dist;
  vqc_argmin #(.CNT(N_CODE), .W(SUM_W), .IW(LOC_W)) u_dim_min (
    .clk(clk), .rst_n(rst_n), .cand_flat(dim_cand),
    .best_idx(dim_code), .best_val(dim_dist)
  );

  // ---- result select and register ----
  logic [GIDX_W-1:0] nxt_idx;
  logic [SUM_W-1:0]  nxt_dist;
  always_comb begin
    if (mode_sel == MODE_DIM) begin
      nxt_idx  = GIDX_W'(dim_code);
      nxt_dist = dim_dist;
    end else begin
      nxt_idx  = {book_unit, book_local};
      nxt_dist = book_dist;
    end
  end

  comb_mode_e res_mode;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_dist  <= '0;
      res_mode  <= MODE_BOOK;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_idx  <= nxt_idx;
        out_dist <= nxt_dist;
        res_mode <= mode_sel;
      end
    end
  end

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_STROBE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_RESULT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
                        !in_valid |=> ($stable(out_idx) && $stable(out_dist))); // R9
  AST_BOOK_RANGE:     assert property (@(posedge clk) disable iff (!rst_n)
                        (out_valid && res_mode == MODE_BOOK) |-> (out_dist >> DIST_W) == '0); // R3
  AST_DIM_UNIT_ZERO:  assert property (@(posedge clk) disable iff (!rst_n)
                        (out_valid && res_mode == MODE_DIM) |-> (out_idx >> LOC_W) == '0); // R6
endmodule

// File: tb/tb_vq_cascade_combiner.sv
module tb_vq_cascade_combiner;
  localparam int NU = 2, NC = 32, DW = 12, UW = 1, LW = 5, GW = 6, SW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic mode_dim = 1'b0;
  logic [NU*DW-1:0]    win_dist_flat = '0;
  logic [NU*LW-1:0]    win_idx_flat = '0;
  logic [NU*NC*DW-1:0] part_dist_flat = '0;
  logic          out_valid;
  logic [GW-1:0] out_idx;
  logic [SW-1:0] out_dist;

  vq_cascade_combiner dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_dim(mode_dim),
    .win_dist_flat(win_dist_flat), .win_idx_flat(win_idx_flat),
    .part_dist_flat(part_dist_flat),
    .out_valid(out_valid), .out_idx(out_idx), .out_dist(out_dist)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int wd [NU];
  int wi [NU];
  int pd [NU][NC];

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic load();
    for (int u = 0; u < NU; u++) begin
      win_dist_flat[u*DW +: DW] = DW'(wd[u]);
      win_idx_flat[u*LW +: LW]  = LW'(wi[u]);
      for (int k = 0; k < NC; k++)
        part_dist_flat[(u*NC+k)*DW +: DW] = DW'(pd[u][k]);
    end
  endtask

  // drive one strobe, result checked one edge later
  task automatic fire(bit m);
    @(negedge clk);
    mode_dim = m;
    load();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic void expect_book(output int ei, output int ed);
    ei = 0; ed = wd[0];
    for (int u = 1; u < NU; u++)
      if (wd[u] < ed) begin ed = wd[u]; ei = u; end
    ei = ei * NC + wi[ei];
  endfunction

  function automatic void expect_dim(output int ei, output int ed);
    ed = -1; ei = 0;
    for (int k = 0; k < NC; k++) begin
      int s = 0;
      for (int u = 0; u < NU; u++) s += pd[u][k];
      if (ed < 0 || s < ed) begin ed = s; ei = k; end
    end
  endfunction

  task automatic run_check(bit m, string req);
    int ei, ed;
    if (m) expect_dim(ei, ed); else expect_book(ei, ed);
    fire(m);
    chk({req, " valid"}, out_valid, 1);
    chk({req, " idx"}, out_idx, ei);
    chk({req, " dist"}, out_dist, ed);
  endtask

  task automatic scramble_parts();
    for (int u = 0; u < NU; u++)
      for (int k = 0; k < NC; k++) pd[u][k] = $urandom_range(0, 4095);
  endtask

  task automatic t_reset();
    chk("R1 valid", out_valid, 0);
    chk("R1 idx", out_idx, 0);
    chk("R1 dist", out_dist, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", out_valid, 0);
    chk("R1 dist after release", out_dist, 0);
  endtask

  task automatic t_book();
    scramble_parts();
    wd[0] = 300; wd[1] = 120; wi[0] = 7; wi[1] = 19;
    run_check(0, "R3 R4 unit1 wins");
    chk("R4 explicit", out_idx, 51);
    wd[0] = 5; wd[1] = 900; wi[0] = 31; wi[1] = 0;
    run_check(0, "R3 R4 unit0 wins");
    chk("R4 explicit unit0", out_idx, 31);
    @(negedge clk);
    chk("R2 single pulse", out_valid, 0);
  endtask

  task automatic t_book_tie();
    wd[0] = 77; wd[1] = 77; wi[0] = 3; wi[1] = 9;
    run_check(0, "R5 tie");
    chk("R5 lower unit", out_idx, 3);
  endtask

  task automatic t_book_ignores_parts();
    wd[0] = 400; wd[1] = 60; wi[0] = 1; wi[1] = 2;
    for (int u = 0; u < NU; u++) for (int k = 0; k < NC; k++) pd[u][k] = 0;
    run_check(0, "R10 book zero parts");
    chk("R10 idx", out_idx, 34);
    scramble_parts();
    run_check(0, "R10 book random parts");
    chk("R10 idx unchanged", out_idx, 34);
    chk("R10 dist unchanged", out_dist, 60);
  endtask

  task automatic t_dim();
    for (int u = 0; u < NU; u++)
      for (int k = 0; k < NC; k++) pd[u][k] = 1000 + 37 * ((k * 7 + u * 3) % 19);
    pd[0][17] = 10; pd[1][17] = 20;
    wd[0] = 0; wd[1] = 0; wi[0] = 31; wi[1] = 31;
    run_check(1, "R6 planted");
    chk("R6 idx 17", out_idx, 17);
    chk("R6 dist 30", out_dist, 30);
    wd[0] = 4095; wd[1] = 1; wi[0] = 5; wi[1] = 6;
    run_check(1, "R10 dim ignores winners");
    chk("R10 dim idx", out_idx, 17);
  endtask

  task automatic t_dim_tie();
    for (int u = 0; u < NU; u++) for (int k = 0; k < NC; k++) pd[u][k] = 500;
    run_check(1, "R7 all equal");
    chk("R7 idx 0", out_idx, 0);
    pd[0][20] = 100; pd[1][20] = 50;
    pd[0][5]  = 50;  pd[1][5]  = 100;
    run_check(1, "R7 two equal minima");
    chk("R7 idx 5", out_idx, 5);
  endtask

  task automatic t_overflow();
    for (int u = 0; u < NU; u++) for (int k = 0; k < NC; k++) pd[u][k] = 4095;
    run_check(1, "R8 full scale");
    chk("R8 dist 8190", out_dist, 8190);
  endtask

  task automatic t_hold();
    int hi, hd;
    wd[0] = 222; wd[1] = 333; wi[0] = 12; wi[1] = 4;
    run_check(0, "R9 setup");
    hi = out_idx; hd = out_dist;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      mode_dim = ~mode_dim;
      win_dist_flat = '0;
      part_dist_flat = '0;
      win_idx_flat = '1;
    end
    @(negedge clk);
    chk("R9 no strobe", out_valid, 0);
    chk("R9 idx held", out_idx, hi);
    chk("R9 dist held", out_dist, hd);
  endtask

  task automatic t_random();
    for (int n = 0; n < 60; n++) begin
      bit m = 1'($urandom_range(0, 1));
      for (int u = 0; u < NU; u++) begin
        wd[u] = $urandom_range(0, 15) * 256;
        wi[u] = $urandom_range(0, NC - 1);
      end
      scramble_parts();
      run_check(m, m ? "R6 random" : "R3 random");
    end
  endtask

  initial begin
    for (int u = 0; u < NU; u++) begin
      wd[u] = 0; wi[u] = 0;
      for (int k = 0; k < NC; k++) pd[u][k] = 0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    t_book();
    t_book_tie();
    t_book_ignores_parts();
    t_dim();
    t_dim_tie();
    t_overflow();
    t_hold();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule